// File: doc/BRIEF.md
# Typed Dual-Bank Register File

This block is the architectural register storage for a small register machine. It keeps two separate banks of eight entries. One bank holds 32-bit integers. The other holds pointers of a parameterized width. Each bank has two combinational read ports and one write port.

Every write is gated by a condition. An integer register is named as the condition. It is read in the same cycle as the write, and the write lands only when that register holds zero. Because integer entry 0 is hardwired to zero, naming it as the condition makes the write unconditional.

The integer write port can store its data unchanged or store its bitwise inverse. The pointer write port can only copy. Entry 0 of the integer bank always reads as zero, and entry 0 of the pointer bank always reads as the null pointer, which is all zeros. The register roles given by a calling convention are a software matter, and this block does not enforce them.

Top module: `dbrf_top`

## Requirements
- R1: While reset is high on a clock edge, every entry of both banks is cleared to zero. After reset, every read index on every read port returns zero.
- R2: Integer index 0 always reads as zero. A write aimed at it is dropped.
- R3: Pointer index 0 always reads as the null value (all zeros at the pointer width). A write aimed at it is dropped.
- R4: An integer write with mode 2'b01 (copy) stores `iw_data` into entry `iw_dst` only when the integer entry selected by `iw_cond` holds exactly zero. When that entry is non-zero, the destination keeps its old value.
- R5: Selecting condition index 0 makes any write unconditional, on either bank.
- R6: An integer write with mode 2'b10 (invert) stores the bitwise inverse of `iw_data`, but only when the condition entry is zero. Otherwise it stores nothing.
- R7: When `pw_en` is 1, the pointer write stores `pw_data` into pointer entry `pw_dst`, but only when the integer entry selected by `pw_cond` is zero.
- R8: Reads are combinational. A write takes effect at the clock edge, so a read of the destination during the write cycle returns the old value. The new value is returned from the next cycle on.
- R9: The two read ports of each bank select their entries independently of each other.
- R10: Integer mode 2'b00 (idle) and mode 2'b11 (reserved) change no entry.
- R11: Both condition tests use the contents from before the edge. An integer write in the same cycle that changes a condition register does not affect the pointer write's condition test in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_rd_a_idx | input | 3 | Integer read port A index |
| int_rd_a_val | output | 32 | Integer read port A value |
| int_rd_b_idx | input | 3 | Integer read port B index |
| int_rd_b_val | output | 32 | Integer read port B value |
| ptr_rd_a_idx | input | 3 | Pointer read port A index |
| ptr_rd_a_val | output | PTR_W | Pointer read port A value |
| ptr_rd_b_idx | input | 3 | Pointer read port B index |
| ptr_rd_b_val | output | PTR_W | Pointer read port B value |
| iw_mode | input | 2 | Integer write mode: 00 idle, 01 copy, 10 invert, 11 reserved (idle) |
| iw_dst | input | 3 | Integer write destination |
| iw_cond | input | 3 | Integer index whose zero value enables the integer write |
| iw_data | input | 32 | Integer write data |
| pw_en | input | 1 | Pointer write request |
| pw_dst | input | 3 | Pointer write destination |
| pw_cond | input | 3 | Integer index whose zero value enables the pointer write |
| pw_data | input | PTR_W | Pointer write data |

## Verification
The bench targets the hardwired entries by writing non-zero data to index 0 of both banks. A design that stored those writes would return the data later instead of zero. It then flips a condition register between non-zero and zero around copies and inversions. A design that inverted the test, or compared only some bits, would write when it should hold.

The bench also reads each destination during its write cycle. A design with a bypass would return the new value one cycle early. Finally, one cycle clears or sets a condition register while a pointer write depends on it. A design that forwarded the new integer value into the condition would take the wrong decision on the pointer write.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;

  // Integer write-port operation select
  typedef enum logic [1:0] {
    WM_IDLE   = 2'b00,
    WM_COPY   = 2'b01,
    WM_INVERT = 2'b10,
    WM_RSVD   = 2'b11
  } wr_mode_e;

  localparam int INT_BITS = 32;

endpackage

// File: rtl/dbrf_bank.sv
// One bank of registers: NRD combinational read ports, one write port,
// entry 0 hardwired to zero on read and protected on write.
module dbrf_bank #(
  parameter int W   = 32,
  parameter int N   = 8,
  parameter int NRD = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NRD-1:0][$clog2(N)-1:0] rd_idx,
  output logic [NRD-1:0][W-1:0]         rd_val,
  input  logic                          wr_en,
  input  logic [$clog2(N)-1:0]          wr_idx,
  input  logic [W-1:0]                  wr_data
);

  localparam int IW = $clog2(N);

  logic [W-1:0] store [N];
  logic         wr_live;

  // Index 0 is never written; it is the constant entry of the bank.
  assign wr_live = wr_en && (wr_idx != IW'(0));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < N; e++) begin
        store[e] <= '0;
      end
    end else if (wr_live) begin
      store[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_val[p] = (rd_idx[p] == IW'(0)) ? '0 : store[rd_idx[p]];
  end

endmodule

// File: rtl/dbrf_wr_gate.sv
// Turns a requested operation and a condition value into a write enable and
// write data. HAS_INV selects whether the invert operation is built.
module dbrf_wr_gate
  import dbrf_pkg::*;
#(
  parameter int W       = 32,
  parameter int CW      = 32,
  parameter bit HAS_INV = 1'b1
) (
  input  wr_mode_e      mode,
  input  logic [CW-1:0] cond_val,
  input  logic [W-1:0]  src,
  output logic          we,
  output logic [W-1:0]  data
);

  logic cond_ok;
  assign cond_ok = (cond_val == '0);

  if (HAS_INV) begin : g_inv
    always_comb begin
      we   = 1'b0;
      data = src;
      unique case (mode)
        WM_COPY:   begin we = cond_ok; data = src;  end
        WM_INVERT: begin we = cond_ok; data = ~src; end
        default:   begin we = 1'b0;    data = src;  end
      endcase
    end
  end else begin : g_copy_only
    assign we   = (mode == WM_COPY) && cond_ok;
    assign data = src;
  end

endmodule

// File: rtl/dbrf_top.sv
module dbrf_top
  import dbrf_pkg::*;
#(
  parameter int INT_W = INT_BITS,
  parameter int PTR_W = 48,
  parameter int REGS  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(REGS)-1:0]   int_rd_a_idx,
  output logic [INT_W-1:0]          int_rd_a_val,
  input  logic [$clog2(REGS)-1:0]   int_rd_b_idx,
  output logic [INT_W-1:0]          int_rd_b_val,
  input  logic [$clog2(REGS)-1:0]   ptr_rd_a_idx,
  output logic [PTR_W-1:0]          ptr_rd_a_val,
  input  logic [$clog2(REGS)-1:0]   ptr_rd_b_idx,
  output logic [PTR_W-1:0]          ptr_rd_b_val,
  input  logic [1:0]                iw_mode,
  input  logic [$clog2(REGS)-1:0]   iw_dst,
  input  logic [$clog2(REGS)-1:0]   iw_cond,
  input  logic [INT_W-1:0]          iw_data,
  input  logic                      pw_en,
  input  logic [$clog2(REGS)-1:0]   pw_dst,
  input  logic [$clog2(REGS)-1:0]   pw_cond,
  input  logic [PTR_W-1:0]          pw_data
);

  localparam int IW       = $clog2(REGS);
  localparam int INT_PORTS = 4;   // two user reads plus two condition reads
  localparam int PTR_PORTS = 2;

  // Integer bank: ports 0/1 serve the user, 2/3 feed the condition tests.
  logic [INT_PORTS-1:0][IW-1:0]    int_idx;
  logic [INT_PORTS-1:0][INT_W-1:0] int_val;
  logic                            int_we;
  logic [INT_W-1:0]                int_wd;

  logic [PTR_PORTS-1:0][IW-1:0]    ptr_idx;
  logic [PTR_PORTS-1:0][PTR_W-1:0] ptr_val;
  logic                            ptr_we;
  logic [PTR_W-1:0]                ptr_wd;

  wr_mode_e int_mode;
  wr_mode_e ptr_mode;

  assign int_mode = wr_mode_e'(iw_mode);
  assign ptr_mode = pw_en ? WM_COPY : WM_IDLE;

  assign int_idx = {pw_cond, iw_cond, int_rd_b_idx, int_rd_a_idx};
  assign ptr_idx = {ptr_rd_b_idx, ptr_rd_a_idx};

  assign int_rd_a_val = int_val[0];
  assign int_rd_b_val = int_val[1];
  assign ptr_rd_a_val = ptr_val[0];
  assign ptr_rd_b_val = ptr_val[1];

  dbrf_wr_gate #(.W(INT_W), .CW(INT_W), .HAS_INV(1'b1)) int_gate_i (
    .mode     (int_mode),
    .cond_val (int_val[2]),
    .src      (iw_data),
    .we       (int_we),
    .data     (int_wd)
  );

  dbrf_wr_gate #(.W(PTR_W), .CW(INT_W), .HAS_INV(1'b0)) ptr_gate_i (
    .mode     (ptr_mode),
    .cond_val (int_val[3]),
    .src      (pw_data),
    .we       (ptr_we),
    .data     (ptr_wd)
  );

  dbrf_bank #(.W(INT_W), .N(REGS), .NRD(INT_PORTS)) int_bank_i (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (int_idx),
    .rd_val  (int_val),
    .wr_en   (int_we),
    .wr_idx  (iw_dst),
    .wr_data (int_wd)
  );

  dbrf_bank #(.W(PTR_W), .N(REGS), .NRD(PTR_PORTS)) ptr_bank_i (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (ptr_idx),
    .rd_val  (ptr_val),
    .wr_en   (ptr_we),
    .wr_idx  (pw_dst),
    .wr_data (ptr_wd)
  );

endmodule

// File: rtl/dbrf_checker.sv
module dbrf_checker #(
  parameter int INT_W = 32,
  parameter int PTR_W = 48,
  parameter int REGS  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [$clog2(REGS)-1:0] int_rd_a_idx,
  input logic [INT_W-1:0]        int_rd_a_val,
  input logic [$clog2(REGS)-1:0] int_rd_b_idx,
  input logic [INT_W-1:0]        int_rd_b_val,
  input logic [$clog2(REGS)-1:0] ptr_rd_a_idx,
  input logic [PTR_W-1:0]        ptr_rd_a_val,
  input logic [$clog2(REGS)-1:0] ptr_rd_b_idx,
  input logic [PTR_W-1:0]        ptr_rd_b_val,
  input logic [1:0]              iw_mode,
  input logic [$clog2(REGS)-1:0] iw_dst,
  input logic [$clog2(REGS)-1:0] iw_cond,
  input logic [INT_W-1:0]        iw_data,
  input logic                    pw_en,
  input logic [$clog2(REGS)-1:0] pw_dst,
  input logic [$clog2(REGS)-1:0] pw_cond,
  input logic [PTR_W-1:0]        pw_data
);

  // R1: the first cycle after reset reads zero everywhere
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (int_rd_a_val == '0 && ptr_rd_a_val == '0));

  // R2
  a_r2_int_zero: assert property (@(posedge clk) disable iff (rst)
    (int_rd_a_idx == '0) |-> (int_rd_a_val == '0));

  // R3
  a_r3_ptr_null: assert property (@(posedge clk) disable iff (rst)
    (ptr_rd_b_idx == '0) |-> (ptr_rd_b_val == '0));

  // R5: an unconditional copy is visible one cycle later
  a_r5_uncond_copy: assert property (@(posedge clk) disable iff (rst)
    (iw_mode == 2'b01 && iw_cond == '0 && iw_dst != '0) |=>
      (!(int_rd_a_idx == $past(iw_dst)) || int_rd_a_val == $past(iw_data)));

  // R6: an unconditional invert stores the complement
  a_r6_invert: assert property (@(posedge clk) disable iff (rst)
    (iw_mode == 2'b10 && iw_cond == '0 && iw_dst != '0) |=>
      (!(int_rd_b_idx == $past(iw_dst)) || int_rd_b_val == ~$past(iw_data)));

  // R7: an unconditional pointer copy is visible one cycle later
  a_r7_ptr_copy: assert property (@(posedge clk) disable iff (rst)
    (pw_en && pw_cond == '0 && pw_dst != '0) |=>
      (!(ptr_rd_b_idx == $past(pw_dst)) || ptr_rd_b_val == $past(pw_data)));

  // R10: no integer write request means the read value holds
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (iw_mode == 2'b00 || iw_mode == 2'b11) |=>
      (!$stable(int_rd_a_idx) || $stable(int_rd_a_val)));

  // R9: pointer port A holds while no pointer write is requested
  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !pw_en |=> (!$stable(ptr_rd_a_idx) || $stable(ptr_rd_a_val)));

endmodule

bind dbrf_top dbrf_checker #(.INT_W(INT_W), .PTR_W(PTR_W), .REGS(REGS)) chk_i (.*);

// File: tb/dbrf_top_tb_top.sv
`timescale 1ns/1ps
module dbrf_top_tb_top;

  localparam int IW_ = 32;
  localparam int PW_ = 48;
  localparam int NR  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    int_rd_a_idx = '0, int_rd_b_idx = '0;
  logic [2:0]    ptr_rd_a_idx = '0, ptr_rd_b_idx = '0;
  logic [IW_-1:0] int_rd_a_val, int_rd_b_val;
  logic [PW_-1:0] ptr_rd_a_val, ptr_rd_b_val;
  logic [1:0]    iw_mode = 2'b00;
  logic [2:0]    iw_dst = '0, iw_cond = '0;
  logic [IW_-1:0] iw_data = '0;
  logic          pw_en = 1'b0;
  logic [2:0]    pw_dst = '0, pw_cond = '0;
  logic [PW_-1:0] pw_data = '0;

  always #2 clk = ~clk;

  dbrf_top #(.INT_W(IW_), .PTR_W(PW_), .REGS(NR)) dut_i (.*);

  typedef struct {
    int          port;   // 0 int A, 1 int B, 2 ptr A, 3 ptr B
    logic [63:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     smp_ev;
  int       n_cmp = 0;
  int       n_bad = 0;
  bit       done  = 0;

  logic [IW_-1:0] im [NR];
  logic [PW_-1:0] pm [NR];

  // Monitor: pops expectations and compares them with the read ports
  initial begin
    forever begin
      @(smp_ev);
      #1;
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [63:0] act;
        it = sb_q.pop_front();
        case (it.port)
          0: act = 64'(int_rd_a_val);
          1: act = 64'(int_rd_b_val);
          2: act = 64'(ptr_rd_a_val);
          default: act = 64'(ptr_rd_b_val);
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int port, input logic [63:0] exp, input string tag);
    sb_item_t it;
    it.port = port; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Drive one write cycle; read destinations during it (old values expected)
  task automatic step(input logic [1:0] im_, input int idst, input int icond,
                      input logic [IW_-1:0] idata, input bit pen, input int pdst,
                      input int pcond, input logic [PW_-1:0] pdata);
    logic ic_ok, pc_ok;
    @(negedge clk);
    iw_mode = im_; iw_dst = 3'(idst); iw_cond = 3'(icond); iw_data = idata;
    pw_en = pen; pw_dst = 3'(pdst); pw_cond = 3'(pcond); pw_data = pdata;
    int_rd_a_idx = 3'(idst); ptr_rd_a_idx = 3'(pdst);
    push(0, 64'(im[idst]), "R8");
    push(2, 64'(pm[pdst]), "R8");
    -> smp_ev;
    ic_ok = (im[icond] == '0);
    pc_ok = (im[pcond] == '0);   // old contents, R11
    @(posedge clk);
    if (pen && pc_ok && pdst != 0) pm[pdst] = pdata;
    if (ic_ok && idst != 0) begin
      if (im_ == 2'b01) im[idst] = idata;
      else if (im_ == 2'b10) im[idst] = ~idata;
    end
  endtask

  task automatic probe(input int ia, input int ib, input int pa, input int pb,
                       input string tag);
    @(negedge clk);
    iw_mode = 2'b00; pw_en = 1'b0;
    int_rd_a_idx = 3'(ia); int_rd_b_idx = 3'(ib);
    ptr_rd_a_idx = 3'(pa); ptr_rd_b_idx = 3'(pb);
    push(0, 64'(im[ia]), tag);
    push(1, 64'(im[ib]), tag);
    push(2, 64'(pm[pa]), tag);
    push(3, 64'(pm[pb]), tag);
    -> smp_ev;
    #2;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin im[i] = '0; pm[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: all entries zero after reset
    for (int i = 0; i < NR; i++) probe(i, NR-1-i, i, NR-1-i, "R1");

    // R5/R7: unconditional fills through condition index 0
    for (int i = 1; i < NR; i++)
      step(2'b01, i, 0, 32'h1000_0000 + 32'(i * 7), 1'b1, i, 0, 48'hA5_0000_0000 + 48'(i));
    for (int i = 1; i < NR; i++) probe(i, i, i, i, "R5");
    probe(3, 5, 6, 2, "R7");

    // R2/R3: writes to index 0 are dropped
    step(2'b01, 0, 0, 32'hDEAD_BEEF, 1'b1, 0, 0, 48'hFFFF_FFFF_FFFF);
    probe(0, 0, 0, 0, "R2");
    probe(0, 4, 0, 4, "R3");

    // R4: condition reg 3 non-zero blocks the copy
    step(2'b01, 2, 3, 32'h0000_1111, 1'b0, 0, 0, '0);
    probe(2, 3, 1, 1, "R4");
    step(2'b01, 3, 0, 32'h0, 1'b0, 0, 0, '0);       // clear reg 3
    step(2'b01, 2, 3, 32'h0000_1111, 1'b0, 0, 0, '0);
    probe(2, 3, 1, 1, "R4");

    // R6: invert gated by condition
    step(2'b10, 4, 3, 32'h0F0F_00FF, 1'b0, 0, 0, '0);
    probe(4, 1, 1, 1, "R6");
    step(2'b10, 5, 6, 32'h1234_5678, 1'b0, 0, 0, '0);   // reg 6 non-zero
    probe(5, 6, 1, 1, "R6");

    // R10: idle and reserved modes change nothing
    step(2'b00, 6, 0, 32'hCAFE_0000, 1'b0, 0, 0, '0);
    step(2'b11, 7, 0, 32'hCAFE_1111, 1'b0, 0, 0, '0);
    probe(6, 7, 1, 1, "R10");

    // R7: pointer copy blocked by non-zero condition, then allowed
    step(2'b00, 0, 0, '0, 1'b1, 5, 1, 48'h1111_2222_3333);
    probe(1, 1, 5, 5, "R7");
    step(2'b00, 0, 0, '0, 1'b1, 5, 3, 48'h1111_2222_3333);
    probe(1, 1, 5, 5, "R7");

    // R11: same-cycle integer write to the condition reg is not seen
    step(2'b01, 7, 0, 32'h0, 1'b1, 6, 7, 48'h0BAD_0BAD_0BAD); // reg7 old non-zero
    probe(7, 7, 6, 6, "R11");
    step(2'b01, 3, 0, 32'h55, 1'b1, 2, 3, 48'h600D_600D_600D); // reg3 old zero
    probe(3, 3, 2, 2, "R11");

    // R9: independent port selection
    probe(2, 4, 5, 6, "R9");
    probe(4, 2, 6, 5, "R9");

    // R1: reset again clears everything
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NR; i++) begin im[i] = '0; pm[i] = '0; end
    probe(4, 7, 5, 6, "R1");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

endmodule